// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block owns the refresh duties of an asynchronous DRAM. Out of reset it keeps the strobes idle for a power-up wait. It then runs a fixed burst of CAS-before-RAS cycles to wake the array, and raises `ready`. From then on a free-running interval timer adds one refresh to a debt counter every interval. The sequencer pays each unit of debt with one CAS-before-RAS cycle on `ras_n`, `cas_n` and `we_n`. Every delay is counted in system clocks. Each one is derived from a nanosecond parameter and the clock period.

An access controller shares the strobes through a request/grant pair. A grant is given only when no refresh is owed and no refresh cycle or precharge is under way. Once given, the grant lasts as long as the request. Refreshes that fall due during a long grant pile up in the debt counter, which saturates. When the grant ends, the owed cycles run back to back. `we_n` is held high throughout, so a refresh cycle can never open the test mode.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted the outputs are as follows. `ras_n`, `cas_n` and `we_n` are 1, and `acc_gnt`, `ready` and `refresh_busy` are 0. `refresh_debt` is 0.
- R2: After reset, no strobe moves for STARTUP_CYC = ceil(STARTUP_NS/CLK_NS) clocks.
- R3: After the wait, INIT_CYCLES refresh cycles run back to back. `ready` rises on the clock after the last precharge clock of the last of them. It rises STARTUP_CYC + INIT_CYCLES*L + 1 clocks after reset release, where L = CSR_CYC + RAS_CYC + RP_CYC. Once high, `ready` stays high.
- R4: Each refresh cycle pulls `cas_n` low for CSR_CYC = ceil(CSR_NS/CLK_NS) clocks before `ras_n` falls. `cas_n` stays low for the whole time `ras_n` is low, and both rise together.
- R5: `we_n` is 1 at every falling edge of `ras_n` and on the clock before it.
- R6: `ras_n` stays low for exactly RAS_CYC = ceil(RAS_NS/CLK_NS) clocks. Both strobes then stay high for RP_CYC = ceil(RP_NS/CLK_NS) clocks before the next cycle can lower `cas_n`.
- R7: Once `ready` is high, `refresh_debt` gains one every REF_CYC = floor(REFRESH_NS/CLK_NS) clocks. With no access traffic, exactly 10 refresh cycles start in any window of 10*REF_CYC clocks.
- R8: `refresh_debt` saturates at DEBT_MAX. When it is non-zero and no grant is held, a refresh cycle starts. Owed cycles follow each other with no idle clock in between, and each start lowers the debt by one.
- R9: A new grant is given only when `ready` is 1, `refresh_debt` is 0 and no refresh cycle or precharge is in progress. A granted request keeps `acc_gnt` high, and `acc_gnt` falls on the clock after `acc_req` falls.
- R10: `refresh_busy` is 1 from the clock `cas_n` falls through the last precharge clock of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | Access side asks for the DRAM strobes |
| acc_gnt | output | 1 | Access side owns the strobes |
| ready | output | 1 | Power-up and wake-up sequence complete |
| refresh_busy | output | 1 | Refresh cycle or its precharge in progress |
| refresh_debt | output | DEBT_W | Refresh cycles owed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |

## Verification
The bench targets several corner cases. The first is the clock on which `ready` rises. A design that declared readiness one cycle early, or that skipped a wake-up cycle, would be off by one clock or by L clocks. The second is a grant held long enough to owe more than DEBT_MAX refreshes. A counter that wrapped would leave almost no debt after release, and one that paid with gaps would stretch the catch-up burst. The third is requests that arrive during a precharge or while debt is pending. A design that granted them would hand the strobes over in the middle of a refresh. Random request toggling is then compared clock by clock against a behavioural model.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [1:0] {
        PH_WAIT,
        PH_INIT,
        PH_RUN
    } phase_e;

    typedef enum logic [1:0] {
        CY_IDLE,
        CY_SETUP,
        CY_ACTIVE,
        CY_PRECH
    } cyc_e;

    // Minimum interval in ns to a cycle count, rounded up, at least one.
    function automatic int ns_to_cyc_up(input int ns, input int per);
        int c;
        c = (ns + per - 1) / per;
        if (c < 1) c = 1;
        return c;
    endfunction

    // Maximum interval in ns to a cycle count, rounded down, at least one.
    function automatic int ns_to_cyc_dn(input int ns, input int per);
        int c;
        c = ns / per;
        if (c < 1) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/rfsh_cycle_gen.sv
module rfsh_cycle_gen
    import dram_rfsh_pkg::*;
#(
    parameter int CSR_CYC = 1,
    parameter int RAS_CYC = 6,
    parameter int RP_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic take,
    output logic done,
    output logic busy,
    output logic ras_n,
    output logic cas_n
);
    localparam int LONG1   = (RAS_CYC > CSR_CYC) ? RAS_CYC : CSR_CYC;
    localparam int LONGEST = (RP_CYC > LONG1) ? RP_CYC : LONG1;
    localparam int CW      = $clog2(LONGEST + 1);

    typedef struct packed {
        cyc_e          st;
        logic [CW-1:0] cnt;
        logic          ras_n;
        logic          cas_n;
    } gen_t;

    gen_t q, d;
    logic last;

    always_comb begin
        d    = q;
        last = (q.st == CY_PRECH) && (q.cnt == '0);
        take = start && ((q.st == CY_IDLE) || last);
        case (q.st)
            CY_IDLE: d = q;
            CY_SETUP: begin
                if (q.cnt == '0) begin
                    d.st    = CY_ACTIVE;
                    d.cnt   = CW'(RAS_CYC - 1);
                    d.ras_n = 1'b0;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            CY_ACTIVE: begin
                if (q.cnt == '0) begin
                    d.st    = CY_PRECH;
                    d.cnt   = CW'(RP_CYC - 1);
                    d.ras_n = 1'b1;
                    d.cas_n = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            CY_PRECH: begin
                if (q.cnt == '0) d.st = CY_IDLE;
                else             d.cnt = q.cnt - 1'b1;
            end
            default: d.st = CY_IDLE;
        endcase
        // A new cycle may begin on the final precharge clock: no idle gap.
        if (take) begin
            d.st    = CY_SETUP;
            d.cnt   = CW'(CSR_CYC - 1);
            d.cas_n = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: CY_IDLE, cnt: '0, ras_n: 1'b1, cas_n: 1'b1};
        else        q <= d;
    end

    assign done  = last;
    assign busy  = (q.st != CY_IDLE);
    assign ras_n = q.ras_n;
    assign cas_n = q.cas_n;

endmodule

// File: rtl/rfsh_debt_timer.sv
module rfsh_debt_timer #(
    parameter int REF_CYC  = 1560,
    parameter int DEBT_MAX = 8,
    parameter int DW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          dec,
    output logic [DW-1:0] debt
);
    localparam int TW = $clog2(REF_CYC + 1);

    typedef struct packed {
        logic [TW-1:0] tmr;
        logic [DW-1:0] debt;
    } tmr_t;

    tmr_t q, d;
    logic tick;

    always_comb begin
        d    = q;
        tick = 1'b0;
        if (run) begin
            if (q.tmr == '0) begin
                tick  = 1'b1;
                d.tmr = TW'(REF_CYC - 1);
            end else begin
                d.tmr = q.tmr - 1'b1;
            end
        end
        if (tick && !dec) begin
            if (q.debt != DW'(DEBT_MAX)) d.debt = q.debt + 1'b1;
        end else if (!tick && dec) begin
            d.debt = q.debt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{tmr: TW'(REF_CYC - 1), debt: '0};
        else        q <= d;
    end

    assign debt = q.debt;

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import dram_rfsh_pkg::*;
#(
    parameter int CLK_NS      = 10,
    parameter int STARTUP_NS  = 200000,
    parameter int REFRESH_NS  = 15600,
    parameter int CSR_NS      = 5,
    parameter int RAS_NS      = 60,
    parameter int RP_NS       = 40,
    parameter int INIT_CYCLES = 8,
    parameter int DEBT_MAX    = 8,
    localparam int DEBT_W     = $clog2(DEBT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    output logic              acc_gnt,
    output logic              ready,
    output logic              refresh_busy,
    output logic [DEBT_W-1:0] refresh_debt,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n
);
    localparam int STARTUP_CYC = ns_to_cyc_up(STARTUP_NS, CLK_NS);
    localparam int CSR_CYC     = ns_to_cyc_up(CSR_NS, CLK_NS);
    localparam int RAS_CYC     = ns_to_cyc_up(RAS_NS, CLK_NS);
    localparam int RP_CYC      = ns_to_cyc_up(RP_NS, CLK_NS);
    localparam int REF_CYC     = ns_to_cyc_dn(REFRESH_NS, CLK_NS);
    localparam int WW          = $clog2(STARTUP_CYC + 1);
    localparam int IW          = $clog2(INIT_CYCLES + 1);

    typedef struct packed {
        phase_e        phase;
        logic [WW-1:0] wait_cnt;
        logic [IW-1:0] init_left;
        logic          gnt;
        logic          we_n;
    } seq_t;

    seq_t q, d;

    logic              start, take, done, busy;
    logic [DEBT_W-1:0] debt;

    // Refresh wins over a fresh grant whenever any debt is owed.
    assign start = ((q.phase == PH_INIT) && (q.init_left != '0)) ||
                   ((q.phase == PH_RUN) && (debt != '0) && !q.gnt);

    rfsh_cycle_gen #(
        .CSR_CYC(CSR_CYC),
        .RAS_CYC(RAS_CYC),
        .RP_CYC (RP_CYC)
    ) u_cyc (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .take (take),
        .done (done),
        .busy (busy),
        .ras_n(ras_n),
        .cas_n(cas_n)
    );

    rfsh_debt_timer #(
        .REF_CYC (REF_CYC),
        .DEBT_MAX(DEBT_MAX),
        .DW      (DEBT_W)
    ) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (q.phase == PH_RUN),
        .dec  (take && (q.phase == PH_RUN)),
        .debt (debt)
    );

    always_comb begin
        d      = q;
        d.we_n = 1'b1;
        case (q.phase)
            PH_WAIT: begin
                if (q.wait_cnt == '0) begin
                    d.phase     = PH_INIT;
                    d.init_left = IW'(INIT_CYCLES);
                end else begin
                    d.wait_cnt = q.wait_cnt - 1'b1;
                end
            end
            PH_INIT: begin
                if (take) d.init_left = q.init_left - 1'b1;
                if ((q.init_left == '0) && done) d.phase = PH_RUN;
            end
            PH_RUN:  d.phase = PH_RUN;
            default: d.phase = PH_WAIT;
        endcase
        if (q.gnt) d.gnt = acc_req;
        else       d.gnt = acc_req && (q.phase == PH_RUN) && !busy && (debt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_WAIT, wait_cnt: WW'(STARTUP_CYC - 1),
                   init_left: '0, gnt: 1'b0, we_n: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign acc_gnt      = q.gnt;
    assign ready        = (q.phase == PH_RUN);
    assign refresh_busy = busy;
    assign refresh_debt = debt;
    assign we_n         = q.we_n;

endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
    parameter int DW       = 4,
    parameter int RAS_CYC  = 6,
    parameter int DEBT_MAX = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ras_n,
    input logic          cas_n,
    input logic          we_n,
    input logic          ready,
    input logic          acc_gnt,
    input logic          refresh_busy,
    input logic [DW-1:0] refresh_debt
);
    int ras_low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ras_low_run <= 0;
        else if (!ras_n) ras_low_run <= ras_low_run + 1;
        else             ras_low_run <= 0;
    end

    assert_cas_leads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n));

    assert_cas_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

    assert_we_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (we_n && $past(we_n)));

    assert_ras_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ras_low_run <= RAS_CYC);

    assert_debt_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_debt <= DW'(DEBT_MAX));

    assert_gnt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_gnt |-> (ras_n && cas_n && !refresh_busy && ready));

    assert_busy_cover_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> refresh_busy);

    assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

endmodule

bind dram_refresh_seq dram_refresh_chk #(
    .DW      (DEBT_W),
    .RAS_CYC (RAS_CYC),
    .DEBT_MAX(DEBT_MAX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .ready       (ready),
    .acc_gnt     (acc_gnt),
    .refresh_busy(refresh_busy),
    .refresh_debt(refresh_debt)
);

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int P_STARTUP  = 2000;
    localparam int P_REFRESH  = 1000;
    localparam int P_INIT     = 8;
    localparam int P_DMAX     = 8;
    // Expected cycle counts from the requirements.
    localparam int SU  = (P_STARTUP + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int CSR = (5 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int RAS = (60 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int RP  = (40 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int REF = P_REFRESH / CLK_PERIOD;
    localparam int L   = CSR + RAS + RP;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_req = 1'b0;
    logic       acc_gnt, ready, refresh_busy, ras_n, cas_n, we_n;
    logic [3:0] refresh_debt;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dram_refresh_seq #(
        .CLK_NS     (CLK_PERIOD),
        .STARTUP_NS (P_STARTUP),
        .REFRESH_NS (P_REFRESH),
        .CSR_NS     (5),
        .RAS_NS     (60),
        .RP_NS      (40),
        .INIT_CYCLES(P_INIT),
        .DEBT_MAX   (P_DMAX)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_req     (acc_req),
        .acc_gnt     (acc_gnt),
        .ready       (ready),
        .refresh_busy(refresh_busy),
        .refresh_debt(refresh_debt),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .we_n        (we_n)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: integers only.
    int m_phase, m_wait, m_init, m_pos, m_debt, m_tmr, m_gnt;
    int cyc_since_rel;

    always @(posedge clk) begin
        int free, start, take, tick, ndebt, ngnt, npos;
        if (!rst_n) begin
            m_phase = 0; m_wait = SU - 1; m_init = 0; m_pos = -1;
            m_debt = 0; m_tmr = REF - 1; m_gnt = 0; cyc_since_rel = 0;
        end else begin
            cyc_since_rel++;
            free  = (m_pos < 0 || m_pos == L - 1) ? 1 : 0;
            start = ((m_phase == 1 && m_init > 0) ||
                     (m_phase == 2 && m_debt > 0 && m_gnt == 0)) ? 1 : 0;
            take  = start & free;
            if (m_gnt != 0) ngnt = acc_req ? 1 : 0;
            else ngnt = (acc_req && m_phase == 2 && m_pos < 0 && m_debt == 0) ? 1 : 0;
            tick = 0;
            if (m_phase == 2) begin
                if (m_tmr == 0) begin tick = 1; m_tmr = REF - 1; end
                else m_tmr--;
                ndebt = m_debt + tick - take;
                if (ndebt > P_DMAX) ndebt = P_DMAX;
                m_debt = ndebt;
            end
            if (take != 0) npos = 0;
            else if (m_pos < 0 || m_pos == L - 1) npos = -1;
            else npos = m_pos + 1;
            if (m_phase == 0) begin
                if (m_wait == 0) begin m_phase = 1; m_init = P_INIT; end
                else m_wait--;
            end else if (m_phase == 1) begin
                if (m_init == 0 && m_pos == L - 1) m_phase = 2;
                if (take != 0) m_init--;
            end
            m_pos = npos;
            m_gnt = ngnt;
        end
    end

    int   ras_falls = 0;
    logic prev_ras = 1'b1;
    int   max_debt = 0;

    always @(negedge clk) begin
        bit e_ras, e_cas;
        if (rst_n) begin
            e_cas = !(m_pos >= 0 && m_pos < CSR + RAS);
            e_ras = !(m_pos >= CSR && m_pos < CSR + RAS);
            check(ras_n == e_ras, "R2/R6 ras_n", int'(ras_n), int'(e_ras));
            check(cas_n == e_cas, "R4 cas_n", int'(cas_n), int'(e_cas));
            check(we_n == 1'b1, "R5 we_n", int'(we_n), 1);
            check(ready == (m_phase == 2), "R3 ready", int'(ready), int'(m_phase == 2));
            check(refresh_busy == (m_pos >= 0), "R10 refresh_busy",
                  int'(refresh_busy), int'(m_pos >= 0));
            check(int'(refresh_debt) == m_debt, "R7/R8 refresh_debt",
                  int'(refresh_debt), m_debt);
            check(int'(acc_gnt) == m_gnt, "R9 acc_gnt", int'(acc_gnt), m_gnt);
            if (prev_ras && !ras_n) ras_falls++;
            if (int'(refresh_debt) > max_debt) max_debt = int'(refresh_debt);
        end
        prev_ras = ras_n;
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] lf;
        int t0, n0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ras_n && cas_n && we_n, "R1 strobes", int'({ras_n, cas_n, we_n}), 7);
        check(!acc_gnt && !ready && !refresh_busy, "R1 flags",
              int'({acc_gnt, ready, refresh_busy}), 0);
        check(refresh_debt == 0, "R1 debt", int'(refresh_debt), 0);
        rst_n = 1'b1;
        // Access asks early: no grant before ready (R9).
        repeat (50) @(negedge clk);
        acc_req = 1'b1;
        while (!ready) @(negedge clk);
        check(cyc_since_rel == SU + P_INIT * L + 1, "R3 ready time",
              cyc_since_rel, SU + P_INIT * L + 1);
        check(ras_falls == P_INIT, "R3 wake-up count", ras_falls, P_INIT);
        @(negedge clk);
        check(acc_gnt == 1'b1, "R9 grant at ready", int'(acc_gnt), 1);
        // Hold grant long enough to owe more than the cap.
        repeat (REF * (P_DMAX + 4)) @(negedge clk);
        check(int'(refresh_debt) == P_DMAX, "R8 saturation", int'(refresh_debt), P_DMAX);
        n0 = ras_falls;
        acc_req = 1'b0;
        repeat (2) @(negedge clk);
        check(refresh_busy == 1'b1, "R8 catch-up starts", int'(refresh_busy), 1);
        repeat (P_DMAX * L - 1) @(negedge clk);
        check(ras_falls - n0 == P_DMAX, "R8 back-to-back", ras_falls - n0, P_DMAX);
        // Random request traffic.
        lf = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[2:0] == 3'd0) acc_req = ~acc_req;
            @(negedge clk);
        end
        acc_req = 1'b0;
        repeat (REF * 2) @(negedge clk);
        // R7: idle refresh rate.
        n0 = ras_falls;
        t0 = cyc_since_rel;
        repeat (REF * 10) @(negedge clk);
        check(ras_falls - n0 == 10, "R7 refresh rate", ras_falls - n0, 10);
        check(cyc_since_rel - t0 == REF * 10, "R7 window", cyc_since_rel - t0, REF * 10);
        check(max_debt == P_DMAX, "R8 max debt seen", max_debt, P_DMAX);
        finish_run();
    end

endmodule